// File: doc/BRIEF.md
# DDR Mode Register Load Unit

This unit keeps the two configuration registers of a double-data-rate SDRAM-style device and turns their contents into the control fields that the rest of the device uses. A load strobe samples a 13-bit address word together with a 2-bit bank selector. Selector 00 targets the main configuration register: burst length, burst ordering, read latency and operating mode. Selector 01 targets the extended register: DLL disable, reduced drive strength and QFC enable.

A load takes effect only when every bank is idle and no burst is running. After a load is accepted, a settle window of `SETTLE` clocks follows, and further loads are refused during it. A DLL-reset request produces a single pulse and is not kept in the register. Reserved field codes raise a flag. A refused load raises an error pulse and leaves both registers as they were.

Top module: `ddr_mode_ctl`

## Requirements
- R1: A load with `bank_sel`=00 writes only the main register, and `bank_sel`=01 writes only the extended register. A load with `bank_sel[1]`=1 changes no output and raises no flag.
- R2: `burst_len` shows the length decoded from address bits [2:0]: code 001 gives 2, 010 gives 4, 011 gives 8. Any other code gives 0 and sets `reserved_flag`.
- R3: `burst_interleave` equals address bit 3 of the last accepted main load (1 means interleaved, 0 means sequential).
- R4: `cas_code` equals address bits [6:4] of the last accepted main load. Only 010 (2 clocks) and 110 (2.5 clocks) are legal; any other value sets `reserved_flag`.
- R5: Address bits [12:7] carry the operating mode. All zero means normal operation. Only bit 8 set is a DLL reset: it gives `dll_reset_pulse` high for exactly the one cycle after the accepted load, and bit 8 is not stored. Any other nonzero pattern sets `reserved_flag` for as long as it stays stored.
- R6: An accepted extended load stores address bit 0 as `dll_disable`, bit 1 as `drive_reduced` and bit 2 as `qfc_enable`, and leaves the main fields unchanged.
- R7: A load with `bank_sel[1]`=0 while `banks_idle`=0 raises `illegal_load` for the next cycle and changes no register. It also does not start the settle window.
- R8: After an accepted load, `busy` is high for exactly `SETTLE` cycles. A load with `bank_sel[1]`=0 that arrives while `busy` is high is refused in the same way as in R7.
- R9: After reset the outputs are: burst length 2, sequential order, `cas_code` 010, all extended fields 0, and `reserved_flag`, `illegal_load`, `dll_reset_pulse` and `busy` all 0.
- R10: Register contents stay the same across cycles that have no accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_cmd | input | 1 | Load strobe, one cycle per load |
| bank_sel | input | 2 | Register selector (00 main, 01 extended) |
| addr | input | 13 | Value word for the load |
| banks_idle | input | 1 | High when all banks are idle and no burst is active |
| burst_len | output | 4 | Decoded burst length (2, 4, 8, or 0 for a reserved code) |
| burst_interleave | output | 1 | 1 for interleaved burst order |
| cas_code | output | 3 | Stored read latency code |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| dll_disable | output | 1 | Extended register: DLL off |
| drive_reduced | output | 1 | Extended register: reduced drive strength |
| qfc_enable | output | 1 | Extended register: QFC function on |
| reserved_flag | output | 1 | Stored main register holds a reserved code |
| illegal_load | output | 1 | Pulse for a refused load |
| busy | output | 1 | Settle window active |

## Verification
The main register is loaded with every legal burst-length code and with reserved ones, with both burst orders, and with both legal and illegal latency codes, so that decode errors are kept apart from storage errors. The operating-mode tests send a clean DLL reset, bit 7 alone, and bit 8 combined with another bit. These separate the pulse from the reserved flag and show whether bit 8 is wrongly kept in the register. Loads are also sent with banks busy, back-to-back inside the settle window, and with the two unused selector values. These expose a gate that lets a write through, a flag that is missing, or a settle window of the wrong length. Long idle stretches between loads test that the register contents are kept.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;

    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;

    // Field layout follows the address bus: opmode = addr[12:7], blen = addr[2:0]
    typedef struct packed {
        logic [5:0] opmode;
        logic [2:0] cas;
        logic       interleave;
        logic [2:0] blen;
    } main_reg_t;

    typedef struct packed {
        logic qfc;
        logic drive_reduced;
        logic dll_off;
    } ext_reg_t;

    localparam logic [BANK_W-1:0] SEL_MAIN = 2'b00;
    localparam logic [BANK_W-1:0] SEL_EXT  = 2'b01;

    localparam logic [5:0] OP_NORMAL    = 6'b000000;
    localparam logic [5:0] OP_DLL_RESET = 6'b000010;   // only addr[8] set

    localparam main_reg_t MAIN_RESET = '{opmode: 6'd0, cas: 3'b010,
                                         interleave: 1'b0, blen: 3'b001};
    localparam ext_reg_t  EXT_RESET  = '{qfc: 1'b0, drive_reduced: 1'b0,
                                         dll_off: 1'b0};

endpackage

// File: rtl/ddr_mode_decode.sv
module ddr_mode_decode
    import ddr_mode_pkg::*;
(
    input  main_reg_t  regs,
    output logic [3:0] burst_len,
    output logic       interleave,
    output logic [2:0] cas_code,
    output logic       reserved
);
    logic bl_bad;
    logic cl_bad;
    logic op_bad;

    always_comb begin
        bl_bad = 1'b0;
        unique case (regs.blen)
            3'b001:  burst_len = 4'd2;
            3'b010:  burst_len = 4'd4;
            3'b011:  burst_len = 4'd8;
            default: begin
                burst_len = 4'd0;
                bl_bad    = 1'b1;
            end
        endcase
        cl_bad     = !(regs.cas == 3'b010 || regs.cas == 3'b110);
        // the DLL-reset bit is never stored, so any stored opmode bit is reserved
        op_bad     = (regs.opmode != OP_NORMAL);
        interleave = regs.interleave;
        cas_code   = regs.cas;
        reserved   = bl_bad | cl_bad | op_bad;
    end

endmodule

// File: rtl/ddr_settle_timer.sv
module ddr_settle_timer #(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    generate
        if (SETTLE > 0) begin : g_chk
            AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> busy) else $error("busy not raised");   // R8
        end
    endgenerate

endmodule

// File: rtl/ddr_mode_ctl.sv
module ddr_mode_ctl
    import ddr_mode_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_cmd,
    input  logic [1:0]  bank_sel,
    input  logic [12:0] addr,
    input  logic        banks_idle,
    output logic [3:0]  burst_len,
    output logic        burst_interleave,
    output logic [2:0]  cas_code,
    output logic        dll_reset_pulse,
    output logic        dll_disable,
    output logic        drive_reduced,
    output logic        qfc_enable,
    output logic        reserved_flag,
    output logic        illegal_load,
    output logic        busy
);
    typedef struct packed {
        main_reg_t main;
        ext_reg_t  ext;
        logic      dll_pulse;
        logic      illegal;
    } state_t;

    state_t    st_d;
    state_t    st_q;
    logic      targeted;
    logic      accept;
    main_reg_t incoming;

    always_comb begin
        st_d      = st_q;
        incoming  = main_reg_t'(addr);
        targeted  = load_cmd && !bank_sel[1];
        accept    = targeted && banks_idle && !busy;

        st_d.dll_pulse = 1'b0;
        st_d.illegal   = targeted && !accept;

        if (accept) begin
            if (bank_sel == SEL_MAIN) begin
                st_d.main             = incoming;
                st_d.main.opmode[1]   = 1'b0;                // self-clearing bit
                st_d.dll_pulse        = (incoming.opmode == OP_DLL_RESET);
            end else begin
                st_d.ext.dll_off       = addr[0];
                st_d.ext.drive_reduced = addr[1];
                st_d.ext.qfc           = addr[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.main      <= MAIN_RESET;
            st_q.ext       <= EXT_RESET;
            st_q.dll_pulse <= 1'b0;
            st_q.illegal   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    ddr_mode_decode u_decode (
        .regs       (st_q.main),
        .burst_len  (burst_len),
        .interleave (burst_interleave),
        .cas_code   (cas_code),
        .reserved   (reserved_flag)
    );

    ddr_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy)
    );

    assign dll_reset_pulse = st_q.dll_pulse;
    assign dll_disable     = st_q.ext.dll_off;
    assign drive_reduced   = st_q.ext.drive_reduced;
    assign qfc_enable      = st_q.ext.qfc;
    assign illegal_load    = st_q.illegal;

    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cmd |=> $stable(burst_len) && $stable(cas_code) && $stable(burst_interleave))
        else $error("main fields changed without load");   // R10

    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd && !banks_idle && !bank_sel[1] |=> illegal_load && $stable(burst_len)
            && $stable(dll_disable) && $stable(cas_code))
        else $error("refused load altered state");   // R7

    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && load_cmd && !bank_sel[1] |=> illegal_load && !dll_reset_pulse)
        else $error("load accepted while busy");   // R8

    AST_PULSE_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |-> $past(load_cmd) && ($past(bank_sel) == SEL_MAIN))
        else $error("DLL pulse without main load");   // R5

    AST_BL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        burst_len == 4'd0 |-> reserved_flag)
        else $error("reserved burst code not flagged");   // R2

endmodule

// File: tb/test_ddr_mode_ctl.sv
module test_ddr_mode_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_cmd = 1'b0;
    logic [1:0]  bank_sel = 2'b00;
    logic [12:0] addr = '0;
    logic        banks_idle = 1'b1;
    logic [3:0]  burst_len;
    logic        burst_interleave;
    logic [2:0]  cas_code;
    logic        dll_reset_pulse, dll_disable, drive_reduced, qfc_enable;
    logic        reserved_flag, illegal_load, busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int m_bl = 1, m_bt = 0, m_cl = 2, m_op = 0;
    int m_off = 0, m_drv = 0, m_qfc = 0, m_cnt = 0;
    int m_pulse = 0, m_ill = 0;

    ddr_mode_ctl #(.SETTLE(SETTLE)) i_ddr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .bank_sel(bank_sel),
        .addr(addr), .banks_idle(banks_idle), .burst_len(burst_len),
        .burst_interleave(burst_interleave), .cas_code(cas_code),
        .dll_reset_pulse(dll_reset_pulse), .dll_disable(dll_disable),
        .drive_reduced(drive_reduced), .qfc_enable(qfc_enable),
        .reserved_flag(reserved_flag), .illegal_load(illegal_load), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_len;
        int exp_res;
        case (m_bl)
            1: exp_len = 2;
            2: exp_len = 4;
            3: exp_len = 8;
            default: exp_len = 0;
        endcase
        exp_res = (exp_len == 0 || !(m_cl == 2 || m_cl == 6) || m_op != 0) ? 1 : 0;
        chk("R2 burst_len", 32'(burst_len), exp_len);
        chk("R3 burst_interleave", 32'(burst_interleave), m_bt);
        chk("R4 cas_code", 32'(cas_code), m_cl);
        chk("R5 reserved_flag", 32'(reserved_flag), exp_res);
        chk("R5 dll_reset_pulse", 32'(dll_reset_pulse), m_pulse);
        chk("R6 dll_disable", 32'(dll_disable), m_off);
        chk("R6 drive_reduced", 32'(drive_reduced), m_drv);
        chk("R6 qfc_enable", 32'(qfc_enable), m_qfc);
        chk("R7 illegal_load", 32'(illegal_load), m_ill);
        chk("R8 busy", 32'(busy), (m_cnt != 0) ? 1 : 0);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit ld, input logic [1:0] b, input logic [12:0] a, input bit idle);
        bit tgt;
        bit acc;
        load_cmd = ld; bank_sel = b; addr = a; banks_idle = idle;
        @(posedge clk);
        tgt = ld && !b[1];
        acc = tgt && idle && (m_cnt == 0);
        m_ill   = (tgt && !acc) ? 1 : 0;
        m_pulse = (acc && b == 2'b00 && a[12:7] == 6'b000010) ? 1 : 0;
        if (acc && b == 2'b00) begin
            m_bl = int'(a[2:0]); m_bt = int'(a[3]); m_cl = int'(a[6:4]);
            m_op = int'(a[12:7] & 6'b111101);
        end
        if (acc && b == 2'b01) begin
            m_off = int'(a[0]); m_drv = int'(a[1]); m_qfc = int'(a[2]);
        end
        if (acc) m_cnt = SETTLE;
        else if (m_cnt > 0) m_cnt--;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_for(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 13'd0, 1'b1);
    endtask

    function automatic logic [12:0] mw(input logic [5:0] op, input logic [2:0] cl,
                                       input logic bt, input logic [2:0] bl);
        return {op, cl, bt, bl};
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 reset burst_len", 32'(burst_len), 2);
        chk("R9 reset cas_code", 32'(cas_code), 2);
        chk("R9 reset flags", {reserved_flag, illegal_load, dll_reset_pulse, busy}, 0);
        chk("R9 reset ext", {dll_disable, drive_reduced, qfc_enable}, 0);
        compare_all();

        // R2 R3 R4: legal codes
        cyc(1, 2'b00, mw(6'd0, 3'b110, 1'b1, 3'b010), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'd0, 3'b010, 1'b0, 3'b011), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'd0, 3'b010, 1'b1, 3'b001), 1); idle_for(3);
        // reserved burst / latency codes
        cyc(1, 2'b00, mw(6'd0, 3'b010, 1'b0, 3'b000), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'd0, 3'b010, 1'b0, 3'b111), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'd0, 3'b011, 1'b0, 3'b010), 1); idle_for(3);
        // R5: DLL reset, bit 7 alone, bit 8 plus bit 9
        cyc(1, 2'b00, mw(6'b000010, 3'b010, 1'b0, 3'b010), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'b000001, 3'b010, 1'b0, 3'b010), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'b000110, 3'b110, 1'b0, 3'b011), 1); idle_for(3);
        cyc(1, 2'b00, mw(6'd0, 3'b110, 1'b0, 3'b011), 1); idle_for(3);
        // R6 / R1: extended loads leave main untouched
        cyc(1, 2'b01, 13'b1111111111101, 1); idle_for(3);
        cyc(1, 2'b01, 13'b0000000000010, 1); idle_for(3);
        // R7: banks not idle
        cyc(1, 2'b00, mw(6'd0, 3'b010, 1'b1, 3'b001), 0); idle_for(3);
        cyc(1, 2'b01, 13'b0000000000111, 0); idle_for(3);
        // R8: back-to-back inside the settle window
        cyc(1, 2'b00, mw(6'd0, 3'b010, 1'b0, 3'b010), 1);
        cyc(1, 2'b00, mw(6'b000010, 3'b110, 1'b1, 3'b011), 1);
        cyc(1, 2'b01, 13'b0000000000100, 1);
        cyc(1, 2'b00, mw(6'd0, 3'b110, 1'b1, 3'b011), 1);
        idle_for(4);
        // R1: selector values with bank_sel[1]=1 are ignored
        cyc(1, 2'b10, mw(6'd0, 3'b010, 1'b0, 3'b001), 1); idle_for(2);
        cyc(1, 2'b11, 13'b0000000000111, 0); idle_for(2);
        // R10: contents persist over a long quiet stretch
        idle_for(40);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule